// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds the return addresses of a small processor core. When the core makes a subroutine call or accepts an interrupt, it raises a push request carrying its current program counter. When it executes any return-type instruction, it raises a pop request and receives the saved address in the same cycle, so it can load its program counter directly.

The storage is a private array. It is not mapped into any program or data space, and its pointer cannot be read or written from outside. The pointer wraps freely in both directions. Neither overflow nor underflow is blocked: when more pushes arrive than the stack has entries, the oldest entries are overwritten.

The only status is a registered "stack available" flag. Reset sets the flag. It drops whenever the pointer sits at its top value. Once a push carries the pointer from the top value around to zero, the flag stays low until the next reset. There is no separate underflow indicator: a pop with nothing saved moves the pointer to the top value, and this shows only as the flag going low. The block has no connection to the core's program-counter high-byte latch, so pushes and pops leave that latch untouched.

Top module: `ret_addr_stack`

## Requirements
- R1: After a synchronous reset the pointer is 0 and `stk_avail` is 1. The first push after reset therefore lands in entry 0, and a pop straight after reset reads entry 15.
- R2: A push writes `push_pc` into the entry the pointer names and then advances the pointer by one, modulo 16.
- R3: A pop (with `push_req` low) steps the pointer back by one, modulo 16. In the same cycle, `pop_pc` shows the entry at the stepped-back pointer.
- R4: Pushes followed by pops return the pushed addresses in reverse order.
- R5: The array is circular. With no pops in between, push number 17 overwrites the entry written by push 1, and push 18 overwrites the entry of push 2.
- R6: `stk_avail` is 0 in every cycle where the pointer equals 15. While no lock is set, it is 1 at every other pointer value, including after pops bring the pointer back below 15.
- R7: A push made while the pointer is 15 wraps the pointer to 0 and sets a lock. While the lock is set, `stk_avail` stays 0 whatever pushes and pops follow.
- R8: A pop straight after reset moves the pointer to 15 and clears `stk_avail`. A push that follows before any other pop sets the lock.
- R9: When `push_req` and `pop_req` are both high in one cycle, the push is carried out and the pop is ignored. The pointer advances by one, and the pushed value is the next one popped.
- R10: Only reset releases the lock. After a reset `stk_avail` is 1 again.
- R11: `stk_avail` changes only at a clock edge, one cycle after the request that moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Save `push_pc` (call or interrupt accepted) |
| push_pc | input | 16 | Program counter to save |
| pop_req | input | 1 | Restore an address (return-type instruction) |
| pop_pc | output | 16 | Address being restored; valid in the cycle of `pop_req` |
| stk_avail | output | 1 | Stack available flag, registered |

## Verification
The bench uses the default parameters: 16-bit addresses and a 4-bit pointer. With these values a wrap, and with it the lock, is reached after only 16 pushes, and circular overwrites after 17 or 18. The flag corners are therefore all reachable in a short run: pointer at top, pop from empty, lock, and release by reset. A bench-side model with the same 16 slots predicts every popped address and every flag value. Entries that have never been written are excluded from the data comparison.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } ras_op_e;

  // Push wins over a simultaneous pop.
  function automatic ras_op_e ras_decode(input logic push, input logic pop);
    if (push)     return OP_PUSH;
    else if (pop) return OP_POP;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int PTR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ras_pkg::ras_op_e     op,
  output logic [PTR_W-1:0]     ptr,
  output logic [PTR_W-1:0]     ptr_dn,
  output logic [PTR_W-1:0]     ptr_nxt,
  output logic                 wrap_up
);
  import ras_pkg::*;

  localparam logic [PTR_W-1:0] PTR_TOP = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_up;

  assign ptr_up = ptr_q + ONE;
  assign ptr_dn = ptr_q - ONE;

  always_comb begin
    unique case (op)
      OP_PUSH: ptr_nxt = ptr_up;
      OP_POP:  ptr_nxt = ptr_dn;
      default: ptr_nxt = ptr_q;
    endcase
  end

  assign wrap_up = (op == OP_PUSH) && (ptr_q == PTR_TOP);

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

  a_r1_ptr_reset: assert property (@(posedge clk) rst |=> ptr_q == '0);
  a_r2_push_adv: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH |=> ptr_q == $past(ptr_q) + ONE);
  a_r3_pop_back: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP |=> ptr_q == $past(ptr_q) - ONE);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    op == OP_IDLE |=> $stable(ptr_q));

endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << PTR_W;

  // No reset on the array so it maps onto distributed RAM.
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read: the popped address is available in the request cycle.
  assign rdata = mem[raddr];

  a_r2_write_lands: assert property (@(posedge clk)
    we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/ras_flag.sv
module ras_flag #(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr_nxt,
  input  logic             wrap_up,
  output logic             avail,
  output logic             locked
);
  localparam logic [PTR_W-1:0] PTR_TOP = {PTR_W{1'b1}};

  logic lock_q, lock_nxt, avail_q;

  assign lock_nxt = lock_q | wrap_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      avail_q <= 1'b1;
    end else begin
      lock_q  <= lock_nxt;
      avail_q <= !lock_nxt && (ptr_nxt != PTR_TOP);
    end
  end

  assign avail  = avail_q;
  assign locked = lock_q;

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  a_r7_lock_holds_low: assert property (@(posedge clk) disable iff (rst)
    lock_q |-> !avail_q);
  a_r10_reset_release: assert property (@(posedge clk)
    rst |=> avail_q && !lock_q);

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic [ADDR_W-1:0] push_pc,
  input  logic              pop_req,
  output logic [ADDR_W-1:0] pop_pc,
  output logic              stk_avail
);
  import ras_pkg::*;

  localparam logic [PTR_W-1:0] PTR_TOP = {PTR_W{1'b1}};

  ras_op_e          op;
  logic [PTR_W-1:0] ptr, ptr_dn, ptr_nxt;
  logic             wrap_up, locked;

  assign op = ras_decode(push_req, pop_req);

  ras_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .op(op),
    .ptr(ptr), .ptr_dn(ptr_dn), .ptr_nxt(ptr_nxt), .wrap_up(wrap_up)
  );

  ras_mem #(.DATA_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
    .clk(clk), .we(op == OP_PUSH), .waddr(ptr), .wdata(push_pc),
    .raddr(ptr_dn), .rdata(pop_pc)
  );

  ras_flag #(.PTR_W(PTR_W)) u_flag (
    .clk(clk), .rst(rst), .ptr_nxt(ptr_nxt), .wrap_up(wrap_up),
    .avail(stk_avail), .locked(locked)
  );

  a_r6_top_clears: assert property (@(posedge clk) disable iff (rst)
    ptr == PTR_TOP |-> !stk_avail);
  a_r6_free_sets: assert property (@(posedge clk) disable iff (rst)
    (ptr != PTR_TOP && !locked) |-> stk_avail);
  a_r9_push_wins: assert property (@(posedge clk) disable iff (rst)
    (push_req && pop_req) |=> ptr == $past(ptr) + PTR_W'(1));
  a_r8_pop_from_zero: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && ptr == '0) |=> (ptr == PTR_TOP && !stk_avail));

endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_req = 1'b0, pop_req = 1'b0;
  logic [15:0] push_pc = '0;
  logic [15:0] pop_pc;
  logic        stk_avail;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ret_addr_stack u0 (
    .clk(clk), .rst(rst), .push_req(push_req), .push_pc(push_pc),
    .pop_req(pop_req), .pop_pc(pop_pc), .stk_avail(stk_avail)
  );

  // Reference model
  logic [15:0] m_mem [16];
  bit          m_ok  [16];
  logic [3:0]  m_ptr;
  bit          m_lock;

  // Scoreboard queues for popped data
  bit          q_chk [$];
  logic [15:0] q_val [$];
  string       q_tag [$];

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compares popped data mid-cycle while the pop request is up
  always @(negedge clk) begin
    if (pop_req && !push_req && q_chk.size() > 0) begin
      bit c = q_chk.pop_front();
      logic [15:0] v = q_val.pop_front();
      string t = q_tag.pop_front();
      if (c) check(t, pop_pc, v);
    end
  end

  task automatic do_reset(string tag);
    @(posedge clk); #1;
    rst = 1'b1; push_req = 0; pop_req = 0;
    @(posedge clk); #1;
    rst = 1'b0;
    m_ptr = 0; m_lock = 0;
    check({tag, " avail after reset"}, {15'd0, stk_avail}, 16'd1);
  endtask

  // Driver: one request cycle, then check the registered flag
  task automatic op(bit psh, logic [15:0] pc, bit pp, string tag);
    @(posedge clk); #1;
    push_req = psh; push_pc = pc; pop_req = pp;
    if (psh) begin
      m_mem[m_ptr] = pc; m_ok[m_ptr] = 1;
      if (m_ptr == 4'hF) m_lock = 1;
      m_ptr = m_ptr + 4'd1;
    end else if (pp) begin
      m_ptr = m_ptr - 4'd1;
      q_chk.push_back(m_ok[m_ptr]);
      q_val.push_back(m_mem[m_ptr]);
      q_tag.push_back({tag, " pop data"});
    end
    @(posedge clk); #1;
    push_req = 0; pop_req = 0;
    check({tag, " avail"}, {15'd0, stk_avail},
          {15'd0, (!m_lock && m_ptr != 4'hF)});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_mem[i] = '0; m_ok[i] = 0; end
    m_ptr = 0; m_lock = 0;
    do_reset("R1");
    // R8: underflow then push locks
    op(0, 16'h0, 1, "R8");
    op(1, 16'h1111, 0, "R8");
    op(0, 16'h0, 1, "R7");
    op(0, 16'h0, 1, "R7");
    op(1, 16'h2222, 0, "R7");
    do_reset("R10");
    // R2/R3/R4: LIFO
    op(1, 16'hA001, 0, "R2");
    op(1, 16'hA002, 0, "R2");
    op(1, 16'hA003, 0, "R2");
    op(0, 16'h0, 1, "R4");
    op(0, 16'h0, 1, "R4");
    op(1, 16'hB00B, 0, "R3");
    op(0, 16'h0, 1, "R3");
    op(0, 16'h0, 1, "R4");
    // R1: pop straight after reset reads entry 15 (written earlier by 0x1111)
    do_reset("R1");
    op(0, 16'h0, 1, "R1");
    do_reset("R1");
    // R6: fill to top, back off, return
    for (int i = 0; i < 15; i++) op(1, 16'hC000 + 16'(i), 0, "R6");
    op(0, 16'h0, 1, "R6");
    op(1, 16'hCE0E, 0, "R6");
    // R7/R5: wrap and overwrite
    op(1, 16'hD00F, 0, "R7");
    op(1, 16'hE000, 0, "R5");
    op(1, 16'hE001, 0, "R5");
    for (int i = 0; i < 16; i++) op(0, 16'h0, 1, "R5");
    do_reset("R10");
    // R9: simultaneous requests
    op(1, 16'h5150, 0, "R9");
    op(1, 16'h9999, 1, "R9");
    op(0, 16'h0, 1, "R9");
    op(0, 16'h0, 1, "R9");
    // R11: flag holds in idle cycles
    op(0, 16'h0, 0, "R11");
    op(0, 16'h0, 1, "R11");
    op(0, 16'h0, 0, "R11");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule